// File: doc/BRIEF.md
# Peripheral Bus Adapter Control/Status Register

This block holds the control/status word of one peripheral bus adapter, as the processor sees it through its I/O read and write operations. The word carries two interrupt priority level fields, a transfer-disable control bit, two sticky error bits that the access sequencer sets when an I/O access finds no device, and two interrupt-pending flags that mirror the adapter's high-group and low-group device requests.

A processor write either loads the writable control bits or, when the initialise bit of the written value is set, starts a bus initialisation. An init write fires a one-cycle reset pulse to the devices on the bus and keeps nothing of the written value except the transfer-disable bit. Reads and writes both fold the current request summaries into the pending flags. A read also acknowledges the error bits, clearing them, and returns the word as it stands after that clearing.

A small state machine with two states, `ST_RUN` (idle, pulse low) and `ST_INIT` (pulse high), produces the initialise pulse. The transition `RUN_TO_INIT` or `INIT_TO_INIT` is taken on any init write. The transition `INIT_TO_RUN` or `RUN_TO_RUN` is taken on every other cycle.

Top module: `bus_adapter_csr`

## Requirements
- R1: After reset the register value, the read data and the initialise pulse are all zero.
- R2: A write whose bit 7 (initialise) is 1 loads the register with bit 6 (transfer disable) of the written value only. All other stored bits, including the error bits, become 0 before the pending flags are refreshed.
- R3: A write whose bit 7 is 0 loads bits 6:0 of the written value and clears every other stored bit before the pending flags are refreshed. Bits 17:8 of the written value are ignored.
- R4: After any write, bit 11 (high pending) is 1 exactly when any high-group request input is 1, and bit 10 (low pending) is 1 exactly when any low-group request input is 1.
- R5: A read sets bit 11 if a high-group request is pending and bit 10 if a low-group request is pending. A read never clears either flag. The read then clears bit 17 (timeout) and bit 16 (nonexistent device), and `rd_data` shows the resulting word in the cycle after the read.
- R6: A no-device strobe sets bits 17 and 16. A strobe in the same cycle as a read or write is applied after that access, so the bits stay set, while the read returns them as 0.
- R7: `bus_init` is 1 in the cycle after each init write and 0 in every other cycle.
- R8: `hi_level` shows register bits 5:3 and `lo_level` shows bits 2:0. Bits 15:12 and 9:7 always read 0.
- R9: When a read and a write occur in the same cycle, the write takes effect and `rd_data` is left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Processor write strobe |
| wr_data | input | 18 | Value written |
| rd_en | input | 1 | Processor read strobe |
| rd_data | output | 18 | Word returned by the last read |
| hi_req | input | N_REQ (4) | High-group device requests |
| lo_req | input | N_REQ (4) | Low-group device requests |
| nxm_set | input | 1 | No-device strobe from the access sequencer |
| csr_value | output | 18 | Current register value |
| hi_level | output | 3 | High-group processor level |
| lo_level | output | 3 | Low-group processor level |
| bus_init | output | 1 | One-cycle bus initialise pulse |

## Verification
Every result is due one clock after its stimulus. This applies to register contents, pending flags, read data, error bits set by a strobe, and the initialise pulse, because each passes through exactly one flop. The bench drives each access on a falling edge and holds it across one rising edge. It compares the outputs on the next falling edge and then checks the pulse once more a cycle later to confirm it has dropped. The write sweep covers every value of the low byte against every combination of pending groups, with the upper bits set to show they are ignored.

// File: rtl/csr_pkg.sv
package csr_pkg;
    parameter int CSR_W     = 18;
    parameter int LVL_W     = 3;
    parameter int LO_LSB    = 0;
    parameter int HI_LSB    = LVL_W;
    parameter int DXF_BIT   = 2 * LVL_W;
    parameter int INIT_BIT  = DXF_BIT + 1;
    parameter int LOP_BIT   = 10;
    parameter int HIP_BIT   = 11;
    parameter int NXD_BIT   = 16;
    parameter int TMO_BIT   = 17;

    localparam logic [CSR_W-1:0] ONE       = {{(CSR_W-1){1'b0}}, 1'b1};
    localparam logic [CSR_W-1:0] LVL_MASK  = (ONE << (2 * LVL_W)) - ONE;
    localparam logic [CSR_W-1:0] DXF_MASK  = ONE << DXF_BIT;
    localparam logic [CSR_W-1:0] WR_MASK   = LVL_MASK | DXF_MASK;
    localparam logic [CSR_W-1:0] ERR_MASK  = (ONE << TMO_BIT) | (ONE << NXD_BIT);
    localparam logic [CSR_W-1:0] RDZ_MASK  = ERR_MASK;
    localparam logic [CSR_W-1:0] PEND_MASK = (ONE << HIP_BIT) | (ONE << LOP_BIT);

    typedef enum logic [0:0] {
        ST_RUN  = 1'b0,
        ST_INIT = 1'b1
    } init_state_t;
endpackage

// File: rtl/csr_init_fsm.sv
module csr_init_fsm
    import csr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic init_req,
    output logic bus_init
);
    init_state_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:  state_d = init_req ? ST_INIT : ST_RUN;
            ST_INIT: state_d = init_req ? ST_INIT : ST_RUN;
            default: state_d = ST_RUN;
        endcase
    end

    always_comb begin
        bus_init = 1'b0;
        unique case (state_q)
            ST_RUN:  bus_init = 1'b0;
            ST_INIT: bus_init = 1'b1;
            default: bus_init = 1'b0;
        endcase
    end

    AST_PULSE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        bus_init |-> $past(init_req)); // R7
    AST_PULSE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        init_req |=> bus_init); // R7
endmodule

// File: rtl/csr_reg_core.sv
module csr_reg_core
    import csr_pkg::*;
#(
    parameter int N_REQ = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CSR_W-1:0] wr_data,
    input  logic             rd_en,
    input  logic [N_REQ-1:0] hi_req,
    input  logic [N_REQ-1:0] lo_req,
    input  logic             nxm_set,
    output logic [CSR_W-1:0] csr_q,
    output logic [CSR_W-1:0] rd_q
);
    logic             hi_any, lo_any;
    logic [CSR_W-1:0] pend_bits;
    logic [CSR_W-1:0] csr_d, rd_d;

    assign hi_any = |hi_req;
    assign lo_any = |lo_req;

    always_comb begin
        pend_bits = '0;
        pend_bits[HIP_BIT] = hi_any;
        pend_bits[LOP_BIT] = lo_any;
    end

    always_comb begin
        csr_d = csr_q;
        rd_d  = rd_q;
        if (wr_en) begin
            if (wr_data[INIT_BIT]) csr_d = wr_data & DXF_MASK;
            else                   csr_d = wr_data & WR_MASK;
            csr_d = csr_d | pend_bits;
        end else if (rd_en) begin
            csr_d = (csr_q | pend_bits) & ~RDZ_MASK;
            rd_d  = csr_d;
        end
        if (nxm_set) csr_d = csr_d | ERR_MASK;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            csr_q <= '0;
            rd_q  <= '0;
        end else begin
            csr_q <= csr_d;
            rd_q  <= rd_d;
        end
    end

    AST_INIT_KEEPS_DXF: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[INIT_BIT] && !nxm_set) |=>
        ((csr_q & ~PEND_MASK) == ($past(wr_data) & DXF_MASK))); // R2
    AST_WRITE_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_data[INIT_BIT] && !nxm_set) |=>
        ((csr_q & ~PEND_MASK) == ($past(wr_data) & WR_MASK))); // R3
    AST_WRITE_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (csr_q[HIP_BIT] == $past(|hi_req)) && (csr_q[LOP_BIT] == $past(|lo_req))); // R4
    AST_READ_ACKS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !wr_en) |=> (rd_q[TMO_BIT] == 1'b0) && (rd_q[NXD_BIT] == 1'b0)); // R5
    AST_READ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !wr_en && csr_q[HIP_BIT]) |=> csr_q[HIP_BIT]); // R5
    AST_NXM_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        nxm_set |=> (csr_q[TMO_BIT] && csr_q[NXD_BIT])); // R6
    AST_COLLIDE: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && wr_en) |=> $stable(rd_q)); // R9
endmodule

// File: rtl/bus_adapter_csr.sv
module bus_adapter_csr
    import csr_pkg::*;
#(
    parameter int N_REQ = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CSR_W-1:0] wr_data,
    input  logic             rd_en,
    output logic [CSR_W-1:0] rd_data,
    input  logic [N_REQ-1:0] hi_req,
    input  logic [N_REQ-1:0] lo_req,
    input  logic             nxm_set,
    output logic [CSR_W-1:0] csr_value,
    output logic [LVL_W-1:0] hi_level,
    output logic [LVL_W-1:0] lo_level,
    output logic             bus_init
);
    logic init_req;

    assign init_req = wr_en & wr_data[INIT_BIT];

    csr_reg_core #(.N_REQ(N_REQ)) core_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .rd_en   (rd_en),
        .hi_req  (hi_req),
        .lo_req  (lo_req),
        .nxm_set (nxm_set),
        .csr_q   (csr_value),
        .rd_q    (rd_data)
    );

    csr_init_fsm fsm_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .init_req (init_req),
        .bus_init (bus_init)
    );

    assign hi_level = csr_value[HI_LSB +: LVL_W];
    assign lo_level = csr_value[LO_LSB +: LVL_W];

    AST_LEVEL_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_data[INIT_BIT]) |=>
        (hi_level == $past(wr_data[HI_LSB +: LVL_W])) && (lo_level == $past(wr_data[LO_LSB +: LVL_W]))); // R8
endmodule

// File: tb/bus_adapter_csr_tb_top.sv
`timescale 1ns/1ps
module bus_adapter_csr_tb_top;
    localparam int W = 18;
    localparam int NR = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [W-1:0]  wr_data = '0;
    logic          rd_en = 1'b0;
    logic [W-1:0]  rd_data;
    logic [NR-1:0] hi_req = '0;
    logic [NR-1:0] lo_req = '0;
    logic          nxm_set = 1'b0;
    logic [W-1:0]  csr_value;
    logic [2:0]    hi_level, lo_level;
    logic          bus_init;

    int n_checks = 0;
    int n_fail = 0;
    logic [W-1:0] exp_csr = '0;
    logic [W-1:0] exp_rd = '0;

    always #2.5 clk = ~clk;

    bus_adapter_csr #(.N_REQ(NR)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_data), .hi_req(hi_req), .lo_req(lo_req),
        .nxm_set(nxm_set), .csr_value(csr_value), .hi_level(hi_level),
        .lo_level(lo_level), .bus_init(bus_init)
    );

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [W-1:0] pend(input logic h, input logic l);
        pend = (W'(h) << 11) | (W'(l) << 10);
    endfunction

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_write(input logic [W-1:0] d, input logic [NR-1:0] h, input logic [NR-1:0] l, input logic nx);
        wr_en = 1'b1; wr_data = d; hi_req = h; lo_req = l; nxm_set = nx;
        step();
        wr_en = 1'b0; nxm_set = 1'b0;
        exp_csr = (d[7] ? (d & 18'h40) : (d & 18'h7F)) | pend(|h, |l);
        if (nx) exp_csr = exp_csr | 18'h30000;
        check("R2/R3/R4 csr after write", csr_value, exp_csr);
        check("R7 init pulse", {17'b0, bus_init}, {17'b0, d[7]});
        check("R8 hi_level", {15'b0, hi_level}, {15'b0, exp_csr[5:3]});
        check("R8 lo_level", {15'b0, lo_level}, {15'b0, exp_csr[2:0]});
    endtask

    task automatic do_read(input logic [NR-1:0] h, input logic [NR-1:0] l, input logic nx);
        rd_en = 1'b1; hi_req = h; lo_req = l; nxm_set = nx;
        step();
        rd_en = 1'b0; nxm_set = 1'b0;
        exp_rd = (exp_csr | pend(|h, |l)) & ~18'h30000;
        exp_csr = exp_rd | (nx ? 18'h30000 : 18'h0);
        check("R5 read data", rd_data, exp_rd);
        check("R5/R6 csr after read", csr_value, exp_csr);
    endtask

    initial begin
        #(5.0 * 150000);
        n_checks++; n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        @(negedge clk); @(negedge clk);
        // R1 reset state
        check("R1 csr reset", csr_value, '0);
        check("R1 rd reset", rd_data, '0);
        check("R1 init reset", {17'b0, bus_init}, '0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 init idle", {17'b0, bus_init}, '0);

        // R2 R3 R4 R7 R8: sweep the low byte with high garbage, all pending combos
        for (int p = 0; p < 4; p++) begin
            for (int w = 0; w < 256; w++) begin
                logic [NR-1:0] hh, ll;
                hh = p[0] ? NR'(1 << (w % NR)) : '0;
                ll = p[1] ? NR'(1 << ((w + 1) % NR)) : '0;
                do_write(18'h3F000 | 18'(w) | 18'h00F00, hh, ll, 1'b0);
                step();
                check("R7 pulse dropped", {17'b0, bus_init}, '0);
            end
        end

        // R6 strobe, then R3 write clears errors
        do_write(18'h0002D, '0, '0, 1'b0);
        nxm_set = 1'b1; step(); nxm_set = 1'b0;
        exp_csr = exp_csr | 18'h30000;
        check("R6 strobe sets errors", csr_value, exp_csr);
        do_write(18'h00015, '0, '0, 1'b0);
        check("R3 write clears errors", csr_value & 18'h30000, '0);

        // R2 init write clears errors, keeps DXF
        nxm_set = 1'b1; step(); nxm_set = 1'b0; exp_csr = exp_csr | 18'h30000;
        do_write(18'h000FF, '0, 4'h2, 1'b0);
        check("R2 init keeps only DXF", csr_value, 18'h00440);

        // R5 read acknowledges errors, flags sticky
        do_write(18'h0001B, 4'h8, '0, 1'b1);
        do_read('0, '0, 1'b0);
        check("R5 high flag sticky", {17'b0, csr_value[11]}, 18'h1);
        do_read('0, 4'h1, 1'b0);
        check("R5 low flag set by read", {17'b0, rd_data[10]}, 18'h1);

        // R6 strobe with read: read returns cleared, register keeps errors
        do_read('0, '0, 1'b1);
        check("R6 read-strobe collision", csr_value & 18'h30000, 18'h30000);
        do_read('0, '0, 1'b0);

        // R9 read and write in same cycle
        exp_rd = rd_data;
        rd_en = 1'b1;
        do_write(18'h00007, '0, '0, 1'b0);
        rd_en = 1'b0;
        check("R9 rd_data unchanged", rd_data, exp_rd);

        // R7 back-to-back init writes
        wr_en = 1'b1; wr_data = 18'h00080; step();
        check("R7 first init", {17'b0, bus_init}, 18'h1);
        step(); wr_en = 1'b0;
        check("R7 second init", {17'b0, bus_init}, 18'h1);
        step();
        check("R7 pulse ends", {17'b0, bus_init}, '0);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule